// File: doc/BRIEF.md
# Sixteen-Point Radix-2 Inverse FFT

The block turns one frame of sixteen complex frequency-domain samples into sixteen complex time-domain samples. All sixteen inputs arrive together on two wide buses, one for real parts and one for imaginary parts, and a valid strobe marks the cycle that carries a frame. The result appears on two matching output buses with its own valid strobe a fixed number of cycles later. A new frame may enter on every clock cycle, so the block works as a fully parallel, pipelined transform engine.

Internally the input frame is first permuted into bit-reversed index order. Four radix-2 decimation-in-time butterfly stages follow. The first three stages act as two independent eight-point inverse transforms, one on each half of the permuted frame, and a final rank of eight butterflies merges the two halves. Each butterfly forms `a + W·b` and `a − W·b`. Here `W = cos(2πk/16) + j·sin(2πk/16)` uses the positive exponent of the inverse transform and is held as a signed Q1.15 constant. Every stage halves its results with round-half-up, which gives the 1/16 scaling of the inverse transform by the end of the pipeline.

Top module: `ifft16_core`

## Requirements
- R1: For input components of magnitude at most 8192, output sample n equals (1/16)·Σk X[k]·e^{+j2πkn/16} within ±4 LSB in both real and imaginary parts. Sample i of every bus occupies bits [16i+15:16i] in two's complement, and outputs are in natural index order.
- R2: A frame whose only nonzero sample is index 0 with real value A gives every output sample a real part of A/16 and an imaginary part of 0, within ±4 LSB.
- R3: A frame in which all sixteen samples equal the same value C gives output sample 0 equal to C and all other output samples equal to 0, within ±4 LSB.
- R4: The transform uses the positive exponent. A frame holding only a real value A at index 1 gives output sample 4 an imaginary part of +A/16 and a real part of 0, within ±4 LSB.
- R5: `outValid` rises exactly 4 clock cycles after the cycle in which `inValid` was high and a frame was taken. Frames on consecutive cycles each produce their own result, in input order.
- R6: While `rst` is high at a clock edge, `outValid` is low after that edge. Frames still in flight when reset is applied never produce an `outValid`.
- R7: `outValid` is never high unless a frame was accepted 4 cycles earlier, counted from the most recent release of reset.
- R8: While `outValid` is low, `outRe` and `outIm` keep the value of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input frame present this cycle |
| inRe | input | 256 | Real parts of the 16 input samples, 16 bits each |
| inIm | input | 256 | Imaginary parts of the 16 input samples, 16 bits each |
| outValid | output | 1 | Result frame present on the output buses |
| outRe | output | 256 | Real parts of the 16 output samples, 16 bits each |
| outIm | output | 256 | Imaginary parts of the 16 output samples, 16 bits each |

## Verification
A wrong twiddle, a swapped butterfly leg or a mistake in the bit-reversed mapping corrupts several output samples of the very frame that passes through it. It shows up on the output buses 4 cycles after that frame enters, as errors far larger than the rounding tolerance. A sign error in the exponent leaves the impulse and DC frames untouched but flips the imaginary part of the single-tone frame. Faults in the valid pipeline show up as strobes that come a cycle early or late, that are missing after a gap, or that appear after a mid-flight reset. Buses that change while no result is flagged break the hold rule on the very next idle cycle.

// File: rtl/ifft16_pkg.sv
package ifft16_pkg;

  localparam int POINTS      = 16;
  localparam int NSTAGE      = $clog2(POINTS);
  localparam int HALF        = POINTS / 2;
  localparam int SAMPLE_W    = 16;
  localparam int TW_W        = 16;
  localparam int TW_FRAC     = TW_W - 1;
  localparam int ACC_W       = SAMPLE_W + TW_W + 3;
  localparam int BUS_W       = POINTS * SAMPLE_W;
  localparam int HALVE_SHIFT = TW_FRAC + 1;

  localparam logic signed [ACC_W-1:0] ROUND_BIAS = ACC_W'(1) << TW_FRAC;
  localparam logic signed [ACC_W-1:0] SAT_MAX    = (ACC_W'(1) << (SAMPLE_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_MIN    = ~SAT_MAX;

  typedef struct packed {
    logic signed [SAMPLE_W-1:0] re;
    logic signed [SAMPLE_W-1:0] im;
  } cplx_t;

  typedef cplx_t [POINTS-1:0] frame_t;

  // Load strobes from control to datapath, one per stage register.
  typedef struct packed {
    logic [NSTAGE-1:0] load;
  } strobe_t;

  function automatic int bitRev(input int idx);
    int r;
    r = 0;
    for (int b = 0; b < NSTAGE; b++) begin
      if (((idx >> b) & 1) != 0) r = r | (1 << (NSTAGE - 1 - b));
    end
    return r;
  endfunction

  // Real part of exp(+j*2*pi*k/16) in Q1.15; +1.0 clamps to 32767.
  function automatic logic signed [TW_W-1:0] twCos(input int k);
    case (k)
      0:       return 16'sd32767;
      1:       return 16'sd30274;
      2:       return 16'sd23170;
      3:       return 16'sd12540;
      4:       return 16'sd0;
      5:       return -16'sd12540;
      6:       return -16'sd23170;
      7:       return -16'sd30274;
      default: return 16'sd0;
    endcase
  endfunction

  // Imaginary part of exp(+j*2*pi*k/16) in Q1.15.
  function automatic logic signed [TW_W-1:0] twSin(input int k);
    case (k)
      0:       return 16'sd0;
      1:       return 16'sd12540;
      2:       return 16'sd23170;
      3:       return 16'sd30274;
      4:       return 16'sd32767;
      5:       return 16'sd30274;
      6:       return 16'sd23170;
      7:       return 16'sd12540;
      default: return 16'sd0;
    endcase
  endfunction

  // Drop Q15 fraction and halve, rounding half up, then clamp to sample range.
  function automatic logic signed [SAMPLE_W-1:0] roundHalve(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] t;
    t = (acc + ROUND_BIAS) >>> HALVE_SHIFT;
    if (t > SAT_MAX)      t = SAT_MAX;
    else if (t < SAT_MIN) t = SAT_MIN;
    return t[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/ifft16_bfly.sv
module ifft16_bfly
  import ifft16_pkg::*;
#(
  parameter logic signed [TW_W-1:0] W_RE = 16'sd32767,
  parameter logic signed [TW_W-1:0] W_IM = 16'sd0
) (
  input  cplx_t a,
  input  cplx_t b,
  output cplx_t sum,
  output cplx_t diff
);

  localparam logic signed [ACC_W-1:0] WR = ACC_W'(W_RE);
  localparam logic signed [ACC_W-1:0] WI = ACC_W'(W_IM);

  logic signed [ACC_W-1:0] aRe, aIm, bRe, bIm, mRe, mIm;

  always_comb begin
    aRe = ACC_W'(a.re) <<< TW_FRAC;
    aIm = ACC_W'(a.im) <<< TW_FRAC;
    bRe = ACC_W'(b.re);
    bIm = ACC_W'(b.im);
    // Four real products kept at full accumulator width.
    mRe = WR * bRe - WI * bIm;
    mIm = WR * bIm + WI * bRe;
    sum.re  = roundHalve(aRe + mRe);
    sum.im  = roundHalve(aIm + mIm);
    diff.re = roundHalve(aRe - mRe);
    diff.im = roundHalve(aIm - mIm);
  end

endmodule

// File: rtl/ifft16_stage.sv
module ifft16_stage
  import ifft16_pkg::*;
#(
  parameter int STAGE = 0
) (
  input  frame_t x,
  output frame_t y
);

  localparam int SPAN    = 1 << STAGE;
  localparam int TW_STEP = HALF / SPAN;

  cplx_t upper [HALF];
  cplx_t lower [HALF];

  // Stages below NSTAGE-1 never pair samples across the two halves, so they
  // form two eight-point transforms; the last stage merges the halves.
  for (genvar bf = 0; bf < HALF; bf++) begin : g_bf
    localparam int OFS = bf % SPAN;
    localparam int TOP = (bf / SPAN) * 2 * SPAN + OFS;
    localparam int BOT = TOP + SPAN;
    localparam int KTW = OFS * TW_STEP;
    ifft16_bfly #(
      .W_RE(twCos(KTW)),
      .W_IM(twSin(KTW))
    ) i_bfly (
      .a   (x[TOP]),
      .b   (x[BOT]),
      .sum (upper[bf]),
      .diff(lower[bf])
    );
  end

  always_comb begin
    y = '0;
    for (int bf = 0; bf < HALF; bf++) begin
      y[(bf / SPAN) * 2 * SPAN + bf % SPAN]        = upper[bf];
      y[(bf / SPAN) * 2 * SPAN + bf % SPAN + SPAN] = lower[bf];
    end
  end

endmodule

// File: rtl/ifft16_datapath.sv
module ifft16_datapath
  import ifft16_pkg::*;
(
  input  logic    clk,
  input  strobe_t strobe,
  input  frame_t  inFrame,
  output frame_t  outFrame
);

  frame_t stIn  [NSTAGE];
  frame_t stOut [NSTAGE];
  frame_t stReg [NSTAGE];

  always_comb begin
    stIn[0] = '0;
    for (int i = 0; i < POINTS; i++) stIn[0][bitRev(i)] = inFrame[i];
    for (int s = 1; s < NSTAGE; s++) stIn[s] = stReg[s-1];
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    ifft16_stage #(.STAGE(s)) i_stage (
      .x(stIn[s]),
      .y(stOut[s])
    );
  end

  // Data registers carry no reset; they load only on a valid strobe.
  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTAGE; s++) begin
      if (strobe.load[s]) stReg[s] <= stOut[s];
    end
  end

  assign outFrame = stReg[NSTAGE-1];

endmodule

// File: rtl/ifft16_ctrl.sv
module ifft16_ctrl
  import ifft16_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);

  logic [NSTAGE-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[NSTAGE-2:0], inValid};
  end

  assign strobe.load = {validPipe[NSTAGE-2:0], inValid};
  assign outValid    = validPipe[NSTAGE-1];

endmodule

// File: rtl/ifft16_core.sv
module ifft16_core
  import ifft16_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [BUS_W-1:0] inRe,
  input  logic [BUS_W-1:0] inIm,
  output logic             outValid,
  output logic [BUS_W-1:0] outRe,
  output logic [BUS_W-1:0] outIm
);

  strobe_t strobe;
  frame_t  inFrame;
  frame_t  outFrame;

  always_comb begin
    for (int i = 0; i < POINTS; i++) begin
      inFrame[i].re = inRe[i*SAMPLE_W +: SAMPLE_W];
      inFrame[i].im = inIm[i*SAMPLE_W +: SAMPLE_W];
      outRe[i*SAMPLE_W +: SAMPLE_W] = outFrame[i].re;
      outIm[i*SAMPLE_W +: SAMPLE_W] = outFrame[i].im;
    end
  end

  ifft16_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  ifft16_datapath i_datapath (
    .clk     (clk),
    .strobe  (strobe),
    .inFrame (inFrame),
    .outFrame(outFrame)
  );

endmodule

// File: rtl/ifft16_checker.sv
module ifft16_checker
  import ifft16_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [BUS_W-1:0] outRe,
  input logic [BUS_W-1:0] outIm
);

  // Number of edges since reset release, saturating.
  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                   sinceRst <= 3'd0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd4) |-> (outValid == $past(inValid, 4)));

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> !outValid);

  assert_no_early_valid_R7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinceRst >= 3'd4));

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst >= 3'd1) && !outValid) |-> ($stable(outRe) && $stable(outIm)));

endmodule

bind ifft16_core ifft16_checker i_checker (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .outRe   (outRe),
  .outIm   (outIm)
);

// File: tb/test_ifft16_core.sv
`timescale 1ns/1ps
module test_ifft16_core;
  import ifft16_pkg::*;

  localparam int NF  = 40;
  localparam real PI = 3.14159265358979323846;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [BUS_W-1:0] inRe = '0;
  logic [BUS_W-1:0] inIm = '0;
  logic             outValid;
  logic [BUS_W-1:0] outRe;
  logic [BUS_W-1:0] outIm;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cyc     = 0;
  int  txIdx   = 0;
  int  rxIdx   = 0;
  bit  monOn   = 1'b0;

  int  frRe [NF][POINTS];
  int  frIm [NF][POINTS];
  real exRe [NF][POINTS];
  real exIm [NF][POINTS];
  int  issueCyc [NF];

  ifft16_core i_ifft16_core (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sampleOf(input logic [BUS_W-1:0] bus, input int idx);
    logic signed [SAMPLE_W-1:0] v;
    v = bus[idx*SAMPLE_W +: SAMPLE_W];
    return int'(v);
  endfunction

  // Floating-point inverse DFT with 1/16 scaling and positive exponent.
  task automatic computeRef(input int f);
    for (int n = 0; n < POINTS; n++) begin
      real sr, si, ang;
      sr = 0.0; si = 0.0;
      for (int k = 0; k < POINTS; k++) begin
        ang = 2.0 * PI * real'(k * n) / real'(POINTS);
        sr += real'(frRe[f][k]) * $cos(ang) - real'(frIm[f][k]) * $sin(ang);
        si += real'(frRe[f][k]) * $sin(ang) + real'(frIm[f][k]) * $cos(ang);
      end
      exRe[f][n] = sr / real'(POINTS);
      exIm[f][n] = si / real'(POINTS);
    end
  endtask

  task automatic checkVal(input string tag, input string what, input int act, input real expv);
    real d;
    d = real'(act) - expv;
    nChecks++;
    if (d > 4.0 || d < -4.0) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0.2f", tag, what, act, expv);
    end
  endtask

  task automatic checkBit(input string tag, input string what, input logic act, input logic expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  task automatic driveFrame(input int f);
    for (int i = 0; i < POINTS; i++) begin
      inRe[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(frRe[f][i]);
      inIm[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(frIm[f][i]);
    end
  endtask

  // Output monitor: compares each result against its own frame.
  always @(negedge clk) begin
    if (monOn && outValid) begin
      if (rxIdx >= txIdx) begin
        nChecks++; nFails++;
        $display("FAIL R7 outValid with no pending frame actual=1 expected=0");
      end else begin
        string tag;
        tag = (rxIdx == 0) ? "R2" : (rxIdx == 1) ? "R3" : (rxIdx == 2) ? "R4" : "R1";
        nChecks++;
        if (cyc != issueCyc[rxIdx] + 4) begin
          nFails++;
          $display("FAIL R5 latency of frame %0d actual=%0d expected=%0d",
                   rxIdx, cyc - issueCyc[rxIdx], 4);
        end
        for (int n = 0; n < POINTS; n++) begin
          checkVal(tag, $sformatf("frame %0d re[%0d]", rxIdx, n), sampleOf(outRe, n), exRe[rxIdx][n]);
          checkVal(tag, $sformatf("frame %0d im[%0d]", rxIdx, n), sampleOf(outIm, n), exIm[rxIdx][n]);
        end
        rxIdx++;
      end
    end
  end

  initial begin
    #(4 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [BUS_W-1:0] holdRe, holdIm;
    int unsigned seedInit;
    seedInit = $urandom(32'd7719);

    // Stimulus set: impulse (R2), DC (R3), single tone (R4), random (R1).
    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < POINTS; i++) begin
        frRe[f][i] = int'($urandom % 16384) - 8192;
        frIm[f][i] = int'($urandom % 16384) - 8192;
        if (f <= 2) begin frRe[f][i] = 0; frIm[f][i] = 0; end
        if (f == 1) begin frRe[f][i] = 3200; frIm[f][i] = -1600; end
      end
      if (f == 0) frRe[f][0] = 4000;
      if (f == 2) frRe[f][1] = 8000;
      computeRef(f);
    end

    // Reset state (R6).
    repeat (3) @(negedge clk);
    checkBit("R6", "outValid during reset", outValid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    checkBit("R6", "outValid after reset release", outValid, 1'b0);

    // A frame caught in flight by reset must vanish (R6).
    for (int i = 0; i < POINTS; i++) begin frRe[0][i] = frRe[0][i]; end
    driveFrame(5);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      checkBit("R6", "outValid after mid-flight reset", outValid, 1'b0);
    end

    // Main run: back-to-back frames with occasional gaps (R1..R5).
    monOn = 1'b1;
    for (int f = 0; f < NF; f++) begin
      driveFrame(f);
      inValid = 1'b1;
      issueCyc[f] = cyc;
      txIdx++;
      @(negedge clk);
      if (f % 7 == 6) begin
        inValid = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    inValid = 1'b0;
    repeat (8) @(negedge clk);

    nChecks++;
    if (rxIdx != NF) begin
      nFails++;
      $display("FAIL R5 frames returned actual=%0d expected=%0d", rxIdx, NF);
    end

    // Idle: no strobe (R7) and buses hold the last result (R8).
    holdRe = outRe;
    holdIm = outIm;
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      checkBit("R7", "outValid while idle", outValid, 1'b0);
      nChecks++;
      if (outRe !== holdRe || outIm !== holdIm) begin
        nFails++;
        $display("FAIL R8 output changed while idle actual=%h expected=%h", outRe, holdRe);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule